// File: doc/BRIEF.md
# Boot-Mode Aware External Bus Gate

This block sits between a CPU's memory port and the pins of an external expansion bus. For every access it decides whether the cycle is served inside the chip (boot ROM, RAM, display memory or I/O registers) or goes out on the external bus. For external cycles it drives an active-low chip enable and an active-low read or write strobe. It also drives the data-bus output enable. For internal cycles all external pins stay idle.

A boot-mode pin is sampled while reset is held low, and the last sampled value is kept once reset is released. With the pin high, the chip boots from internal ROM, which covers the low 32 KB of the address space. With the pin low, the chip boots from external memory, and that same 32 KB window is handed to the external bus.

A two-bit bus-mode register sits in the I/O space. Software writes it to choose between single-chip operation and three expansion modes. Each expansion mode sets how far the external address reach extends. The single-chip setting is refused while the chip boots from external memory.

Top module: `chip_bus_gate`

## Requirements
- R1: `boot_from_ext` takes the inverse of `mode_pin` as sampled on the last clock edge with `rst_n` low. Changes on `mode_pin` after reset release have no effect until `rst_n` goes low again.
- R2: With internal boot (`boot_from_ext`=0), any access to 0x000000–0x007FFF asserts `int_sel` and leaves `ext_ce_n`, `ext_rd_n` and `ext_wr_n` high.
- R3: Accesses to RAM 0x00F000–0x00F7FF, display memory 0x00F800–0x00FCFF and I/O 0x00FF00–0x00FFFF are internal in both boot modes. They assert `int_sel` with no external strobe, even when the external reach would cover the address.
- R4: With external boot, an access to 0x000000–0x007FFF is external: `ext_ce_n` goes low together with `ext_rd_n` (read) or `ext_wr_n` (write), and a read returns `ext_din` on `cpu_rdata`.
- R5: During an external write, `ext_doe` is 1 and `ext_dout` equals `cpu_wdata`. `ext_doe` is 0 in every other cycle, and `ext_addr` follows `cpu_addr`.
- R6: After reset, `bus_mode` is 0 (single-chip) with internal boot and 3 (full reach, the default of EXT_BOOT_MODE) with external boot.
- R7: A write to 0x00FF80 loads `cpu_wdata[1:0]` into `bus_mode` on the next clock edge. A read of 0x00FF80 returns `bus_mode` in bits [1:0] with zeros above.
- R8: With external boot, a write of 0 to 0x00FF80 is ignored and `bus_mode` keeps its old value.
- R9: In bus mode 0, an access outside the internal regions produces no external strobe, and a read returns 0xFF.
- R10: Bus mode 1 reaches external addresses below 0x010000, mode 2 below 0x100000, and mode 3 the whole space. An access beyond the reach behaves as in R9.
- R11: With neither `cpu_rd` nor `cpu_wr` high, no strobe is active and `int_sel` is 0. With both high, the cycle is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; boot pin is sampled while low |
| mode_pin | input | 1 | Boot-mode pin, 1 = internal ROM boot |
| cpu_addr | input | 24 | CPU access address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data for external, register and unmapped reads |
| ext_din | input | 8 | Data from the external bus |
| ext_addr | output | 24 | External address |
| ext_dout | output | 8 | Data to the external bus |
| ext_doe | output | 1 | External data-bus output enable |
| ext_ce_n | output | 1 | External chip enable, active low |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| int_sel | output | 1 | Access served internally |
| bus_mode | output | 2 | Current bus mode |
| boot_from_ext | output | 1 | Latched boot mode, 1 = external boot |

## Verification
The hardest case to reach is the refused single-chip write. It needs a reset with the pin low, an expansion mode moved away from its reset value, and then a write of 0 to the mode register. The bench does this in that order and reads the register back through the bus, so a write that was taken is told apart from a write that was refused. Overlap between internal regions and the external reach is covered by accessing RAM and I/O addresses while the reach is widest.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

   typedef enum logic [1:0] {
      BM_SINGLE  = 2'd0,
      BM_EXP64K  = 2'd1,
      BM_EXP1M   = 2'd2,
      BM_EXPFULL = 2'd3
   } bus_mode_e;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   typedef struct packed {
      logic internal;
      logic mode_reg;
      logic ext_ok;
   } route_t;

   // write has priority when both requests are raised
   function automatic acc_kind_e classify(input logic rd, input logic wr);
      if (wr)      return ACC_WRITE;
      else if (rd) return ACC_READ;
      else         return ACC_IDLE;
   endfunction

endpackage

// File: rtl/cbg_boot_latch.sv
module cbg_boot_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_pin,
   output logic boot_ext
);
   // follows the pin while reset is held, frozen after release
   always_ff @(posedge clk) begin
      if (!rst_n) boot_ext <= ~mode_pin;
   end
endmodule

// File: rtl/cbg_mode_reg.sv
module cbg_mode_reg
   import cbg_pkg::*;
#(
   parameter int unsigned EXT_BOOT_MODE = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mode_pin,
   input  logic      boot_ext,
   input  logic      wr_en,
   input  logic [1:0] wdata,
   output bus_mode_e mode
);
   localparam bus_mode_e EXT_RST = bus_mode_e'(EXT_BOOT_MODE[1:0]);

   logic refuse;
   assign refuse = boot_ext && (bus_mode_e'(wdata) == BM_SINGLE);

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode <= mode_pin ? BM_SINGLE : EXT_RST;
      else if (wr_en && !refuse)
         mode <= bus_mode_e'(wdata);
   end
endmodule

// File: rtl/cbg_addr_decode.sv
module cbg_addr_decode
   import cbg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter logic [ADDR_W-1:0] ROM_BASE  = 'h000000,
   parameter logic [ADDR_W-1:0] ROM_LAST  = 'h007FFF,
   parameter logic [ADDR_W-1:0] RAM_BASE  = 'h00F000,
   parameter logic [ADDR_W-1:0] RAM_LAST  = 'h00F7FF,
   parameter logic [ADDR_W-1:0] DISP_BASE = 'h00F800,
   parameter logic [ADDR_W-1:0] DISP_LAST = 'h00FCFF,
   parameter logic [ADDR_W-1:0] IO_BASE   = 'h00FF00,
   parameter logic [ADDR_W-1:0] IO_LAST   = 'h00FFFF,
   parameter logic [ADDR_W-1:0] MREG_ADDR = 'h00FF80,
   parameter int unsigned REACH1_W  = 16,
   parameter int unsigned REACH2_W  = 20
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              boot_ext,
   input  bus_mode_e         mode,
   output route_t            route
);
   localparam int unsigned NFIX = 3;
   localparam logic [ADDR_W-1:0] FIX_LO [NFIX] = '{RAM_BASE, DISP_BASE, IO_BASE};
   localparam logic [ADDR_W-1:0] FIX_HI [NFIX] = '{RAM_LAST, DISP_LAST, IO_LAST};
   localparam int unsigned REACH_W [4] = '{0, REACH1_W, REACH2_W, ADDR_W};

   logic [NFIX-1:0] fix_hit;
   logic            rom_in;
   logic            rom_hit;
   logic [3:0]      reach_ok;

   // regions that stay internal in every boot mode
   for (genvar g = 0; g < NFIX; g++) begin : g_fix
      assign fix_hit[g] = (addr >= FIX_LO[g]) && (addr <= FIX_HI[g]);
   end

   if (ROM_BASE == '0) begin : g_rom_zero
      assign rom_in = (addr <= ROM_LAST);
   end else begin : g_rom_off
      assign rom_in = (addr >= ROM_BASE) && (addr <= ROM_LAST);
   end

   assign rom_hit = rom_in && !boot_ext;

   // external reach per bus mode
   assign reach_ok[0] = 1'b0;
   for (genvar m = 1; m < 4; m++) begin : g_reach
      if (REACH_W[m] >= ADDR_W) begin : g_all
         assign reach_ok[m] = 1'b1;
      end else begin : g_lim
         assign reach_ok[m] = (addr[ADDR_W-1:REACH_W[m]] == '0);
      end
   end

   always_comb begin
      route.internal = rom_hit || (|fix_hit);
      route.mode_reg = (addr == MREG_ADDR);
      route.ext_ok   = !route.internal && reach_ok[mode];
   end
endmodule

// File: rtl/cbg_strobe_gen.sv
module cbg_strobe_gen
   import cbg_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  acc_kind_e         kind,
   input  route_t            route,
   input  bus_mode_e         mode,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] ext_din,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ext_dout,
   output logic              ext_doe,
   output logic              ext_ce_n,
   output logic              ext_rd_n,
   output logic              ext_wr_n,
   output logic              int_sel,
   output logic              mreg_we
);
   logic ext_cyc;

   assign ext_cyc  = route.ext_ok && (kind != ACC_IDLE);
   assign ext_ce_n = !ext_cyc;
   assign ext_rd_n = !(ext_cyc && kind == ACC_READ);
   assign ext_wr_n = !(ext_cyc && kind == ACC_WRITE);
   assign ext_doe  = ext_cyc && kind == ACC_WRITE;
   assign ext_dout = wdata;
   assign int_sel  = route.internal && (kind != ACC_IDLE);
   assign mreg_we  = route.mode_reg && (kind == ACC_WRITE);

   always_comb begin
      if (ext_cyc)
         rdata = ext_din;
      else if (route.mode_reg)
         rdata = {{(DATA_W-2){1'b0}}, mode};
      else if (route.internal)
         rdata = '0;
      else
         rdata = '1;
   end
endmodule

// File: rtl/chip_bus_gate.sv
module chip_bus_gate
   import cbg_pkg::*;
#(
   parameter int unsigned ADDR_W        = 24,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned EXT_BOOT_MODE = 3,
   parameter int unsigned REACH1_W      = 16,
   parameter int unsigned REACH2_W      = 20,
   parameter logic [ADDR_W-1:0] ROM_BASE  = 'h000000,
   parameter logic [ADDR_W-1:0] ROM_LAST  = 'h007FFF,
   parameter logic [ADDR_W-1:0] RAM_BASE  = 'h00F000,
   parameter logic [ADDR_W-1:0] RAM_LAST  = 'h00F7FF,
   parameter logic [ADDR_W-1:0] DISP_BASE = 'h00F800,
   parameter logic [ADDR_W-1:0] DISP_LAST = 'h00FCFF,
   parameter logic [ADDR_W-1:0] IO_BASE   = 'h00FF00,
   parameter logic [ADDR_W-1:0] IO_LAST   = 'h00FFFF,
   parameter logic [ADDR_W-1:0] MREG_ADDR = 'h00FF80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_pin,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [DATA_W-1:0] ext_din,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_dout,
   output logic              ext_doe,
   output logic              ext_ce_n,
   output logic              ext_rd_n,
   output logic              ext_wr_n,
   output logic              int_sel,
   output logic [1:0]        bus_mode,
   output logic              boot_from_ext
);
   // elaboration-time parameter checks
   if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_aw
      $error("ADDR_W out of range");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("DATA_W too small for mode readback");
   end
   if (EXT_BOOT_MODE == 0 || EXT_BOOT_MODE > 3) begin : g_bad_ebm
      $error("EXT_BOOT_MODE must name an expansion mode");
   end
   if (ROM_LAST < ROM_BASE || IO_LAST < IO_BASE) begin : g_bad_rng
      $error("region bounds reversed");
   end
   if (MREG_ADDR < IO_BASE || MREG_ADDR > IO_LAST) begin : g_bad_mreg
      $error("mode register must sit in I/O space");
   end
   if (!(REACH1_W < REACH2_W && REACH2_W <= ADDR_W)) begin : g_bad_reach
      $error("reach widths must grow");
   end

   logic      boot_ext;
   bus_mode_e mode;
   route_t    route;
   acc_kind_e kind;
   logic      mreg_we;

   assign kind = classify(cpu_rd, cpu_wr);

   cbg_boot_latch u_boot (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_pin (mode_pin),
      .boot_ext (boot_ext)
   );

   cbg_mode_reg #(.EXT_BOOT_MODE(EXT_BOOT_MODE)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_pin (mode_pin),
      .boot_ext (boot_ext),
      .wr_en    (mreg_we),
      .wdata    (cpu_wdata[1:0]),
      .mode     (mode)
   );

   cbg_addr_decode #(
      .ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_LAST(ROM_LAST),
      .RAM_BASE(RAM_BASE), .RAM_LAST(RAM_LAST),
      .DISP_BASE(DISP_BASE), .DISP_LAST(DISP_LAST),
      .IO_BASE(IO_BASE), .IO_LAST(IO_LAST), .MREG_ADDR(MREG_ADDR),
      .REACH1_W(REACH1_W), .REACH2_W(REACH2_W)
   ) u_dec (
      .addr     (cpu_addr),
      .boot_ext (boot_ext),
      .mode     (mode),
      .route    (route)
   );

   cbg_strobe_gen #(.DATA_W(DATA_W)) u_strb (
      .kind     (kind),
      .route    (route),
      .mode     (mode),
      .wdata    (cpu_wdata),
      .ext_din  (ext_din),
      .rdata    (cpu_rdata),
      .ext_dout (ext_dout),
      .ext_doe  (ext_doe),
      .ext_ce_n (ext_ce_n),
      .ext_rd_n (ext_rd_n),
      .ext_wr_n (ext_wr_n),
      .int_sel  (int_sel),
      .mreg_we  (mreg_we)
   );

   assign ext_addr      = cpu_addr;
   assign bus_mode      = mode;
   assign boot_from_ext = boot_ext;
endmodule

// File: rtl/chip_bus_gate_chk.sv
module chip_bus_gate_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              ext_doe,
   input logic              ext_ce_n,
   input logic              ext_rd_n,
   input logic              ext_wr_n,
   input logic              int_sel,
   input logic [1:0]        bus_mode,
   input logic              boot_from_ext
);
   assert_boot_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(boot_from_ext));

   assert_internal_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int_sel |-> (ext_ce_n && ext_rd_n && ext_wr_n && !ext_doe));

   assert_strobe_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_rd_n || !ext_wr_n) |-> (!ext_ce_n && (ext_rd_n != ext_wr_n)));

   assert_doe_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_doe == !ext_wr_n);

   assert_no_single_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
      boot_from_ext |-> (bus_mode != 2'd0));

   assert_unmapped_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mode == 2'd0 && cpu_rd && !cpu_wr && !int_sel)
         |-> (ext_ce_n && cpu_rdata == '1));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rd && !cpu_wr) |-> (ext_ce_n && !int_sel));
endmodule

bind chip_bus_gate chip_bus_gate_chk #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_rd        (cpu_rd),
   .cpu_wr        (cpu_wr),
   .cpu_rdata     (cpu_rdata),
   .ext_doe       (ext_doe),
   .ext_ce_n      (ext_ce_n),
   .ext_rd_n      (ext_rd_n),
   .ext_wr_n      (ext_wr_n),
   .int_sel       (int_sel),
   .bus_mode      (bus_mode),
   .boot_from_ext (boot_from_ext)
);

// File: tb/chip_bus_gate_tb.sv
module chip_bus_gate_tb;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [23:0] MREG = 24'h00FF80;
   localparam logic [7:0]  EXT_PAT = 8'h5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_pin = 1'b1;
   logic [23:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic [7:0]  ext_din = EXT_PAT;
   logic [23:0] ext_addr;
   logic [7:0]  ext_dout;
   logic        ext_doe, ext_ce_n, ext_rd_n, ext_wr_n, int_sel;
   logic [1:0]  bus_mode;
   logic        boot_from_ext;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chip_bus_gate u_dut (
      .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin),
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ext_din(ext_din),
      .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
      .ext_ce_n(ext_ce_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
      .int_sel(int_sel), .bus_mode(bus_mode), .boot_from_ext(boot_from_ext)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // strobes packed as {ce_n, rd_n, wr_n, doe, int_sel}
   function automatic logic [4:0] pins();
      return {ext_ce_n, ext_rd_n, ext_wr_n, ext_doe, int_sel};
   endfunction

   localparam logic [4:0] P_INT  = 5'b11101;
   localparam logic [4:0] P_NONE = 5'b11100;
   localparam logic [4:0] P_XRD  = 5'b00100;
   localparam logic [4:0] P_XWR  = 5'b01010;

   task automatic do_reset(input logic pin);
      @(posedge clk); #1;
      rst_n = 1'b0; mode_pin = pin;
      cpu_rd = 0; cpu_wr = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   // present an access after an edge, sample at the following falling edge
   task automatic access(input logic [23:0] a, input logic rd, input logic wr, input logic [7:0] wd);
      @(posedge clk); #1;
      cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
      @(negedge clk);
   endtask

   task automatic idle();
      @(posedge clk); #1;
      cpu_rd = 0; cpu_wr = 0;
      @(negedge clk);
   endtask

   task automatic mreg_write(input logic [1:0] v);
      access(MREG, 0, 1, {6'b0, v});
      chk("R3 mode reg write internal", pins(), P_INT);
      idle();
   endtask

   task automatic t_reset_int();
      do_reset(1'b1);
      @(negedge clk);
      chk("R1 boot latched internal", boot_from_ext, 1'b0);
      chk("R6 reset mode internal boot", bus_mode, 2'd0);
      chk("R11 idle pins", pins(), P_NONE);
   endtask

   task automatic t_int_rom();
      access(24'h000000, 1, 0, 0); chk("R2 rom base read", pins(), P_INT);
      access(24'h007FFF, 0, 1, 8'h33); chk("R2 rom top write", pins(), P_INT);
      access(24'h004000, 1, 0, 0); chk("R2 rom read data", cpu_rdata, 8'h00);
   endtask

   task automatic t_single_unmapped();
      access(24'h008000, 1, 0, 0);
      chk("R9 unmapped pins", pins(), P_NONE);
      chk("R9 unmapped read ff", cpu_rdata, 8'hFF);
      access(24'h123456, 0, 1, 8'h11);
      chk("R9 unmapped write no strobe", pins(), P_NONE);
   endtask

   task automatic t_reach();
      mreg_write(2'd1);
      chk("R7 mode now 1", bus_mode, 2'd1);
      access(MREG, 1, 0, 0); chk("R7 mode readback", cpu_rdata, 8'h01);
      access(24'h008000, 1, 0, 0); chk("R10 mode1 in reach", pins(), P_XRD);
      chk("R10 ext read data", cpu_rdata, EXT_PAT);
      access(24'h010000, 1, 0, 0); chk("R10 mode1 beyond", pins(), P_NONE);
      chk("R10 mode1 beyond ff", cpu_rdata, 8'hFF);
      mreg_write(2'd2);
      access(24'h0F0000, 1, 0, 0); chk("R10 mode2 in reach", pins(), P_XRD);
      access(24'h100000, 1, 0, 0); chk("R10 mode2 beyond", pins(), P_NONE);
      mreg_write(2'd3);
      access(24'hFFFFF0, 0, 1, 8'hC3); chk("R10 mode3 top write", pins(), P_XWR);
      chk("R5 ext dout", ext_dout, 8'hC3);
      chk("R5 ext addr", ext_addr, 24'hFFFFF0);
      access(24'h000100, 1, 0, 0); chk("R2 rom stays internal in mode3", pins(), P_INT);
   endtask

   task automatic t_overlap();
      access(24'h00F000, 1, 0, 0); chk("R3 ram low", pins(), P_INT);
      access(24'h00F7FF, 0, 1, 1); chk("R3 ram high", pins(), P_INT);
      access(24'h00FCFF, 1, 0, 0); chk("R3 display", pins(), P_INT);
      access(24'h00FF00, 0, 1, 1); chk("R3 io base", pins(), P_INT);
      access(24'h00F800, 1, 0, 0); chk("R3 display data", cpu_rdata, 8'h00);
      access(24'h00FD00, 1, 0, 0); chk("R3 gap goes external", pins(), P_XRD);
   endtask

   task automatic t_both_req();
      access(24'h020000, 1, 1, 8'h77);
      chk("R11 both requests write", pins(), P_XWR);
      idle(); chk("R11 idle after", pins(), P_NONE);
   endtask

   task automatic t_pin_change();
      mode_pin = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 pin change ignored", boot_from_ext, 1'b0);
      access(24'h000010, 1, 0, 0); chk("R1 rom still internal", pins(), P_INT);
   endtask

   task automatic t_ext_boot();
      do_reset(1'b0);
      @(negedge clk);
      chk("R1 boot latched external", boot_from_ext, 1'b1);
      chk("R6 reset mode external boot", bus_mode, 2'd3);
      access(24'h000000, 1, 0, 0); chk("R4 rom window read ext", pins(), P_XRD);
      chk("R4 rom window data", cpu_rdata, EXT_PAT);
      access(24'h007FFF, 0, 1, 8'hA5); chk("R4 rom window write ext", pins(), P_XWR);
      chk("R5 dout ext boot", ext_dout, 8'hA5);
      access(24'h00F100, 1, 0, 0); chk("R3 ram internal ext boot", pins(), P_INT);
      access(24'h00FFC0, 0, 1, 0); chk("R3 io internal ext boot", pins(), P_INT);
      mode_pin = 1'b1;
      idle(); chk("R1 pin ignored ext boot", boot_from_ext, 1'b1);
   endtask

   task automatic t_refuse_single();
      mreg_write(2'd1);
      chk("R7 ext boot mode 1", bus_mode, 2'd1);
      mreg_write(2'd0);
      chk("R8 single refused", bus_mode, 2'd1);
      access(MREG, 1, 0, 0); chk("R8 readback after refuse", cpu_rdata, 8'h01);
      access(24'h00C000, 1, 0, 0); chk("R8 still expanding", pins(), P_XRD);
      mreg_write(2'd2);
      chk("R7 ext boot mode 2", bus_mode, 2'd2);
      idle();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset_int();
      t_int_rom();
      t_single_unmapped();
      t_reach();
      t_overlap();
      t_both_req();
      t_pin_change();
      t_ext_boot();
      t_refuse_single();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule